// File: doc/BRIEF.md
# I/O Activity Detector with Idle-Timer Reload

This block watches the traffic of a legacy I/O space and a handful of side-band hints, and decides when the system is busy. Fixed port windows are decoded for the keyboard controller, the serial ports and the parallel ports. Hint inputs flag video accesses, disk or floppy accesses, primary interrupts and DMA or bus-master cycles. Each of these sources sets its own sticky status bit. A summary flag goes up when a source that software has enabled occurs.

The same events also produce single-cycle reload strobes for two idle timers. The slow timer (GP1) is refreshed by keyboard, serial, video and disk accesses. The fast timer (GP0) is refreshed by any detected source. Each path is gated by its own bit in a reload mask.

A small write-only register port loads the two masks and acknowledges status bits and the summary flag. The status vector and the summary flag are exported directly, so an interrupt controller can consume them.

Top module: `io_activity_monitor`

## Requirements
- R1: A cycle with `io_strobe` high and `io_addr` equal to 0x0060 is keyboard activity and sets status bit 7. The neighbouring address 0x0061 sets nothing.
- R2: A strobed access to any address in 0x03F8-0x03FF, 0x02F8-0x02FF, 0x03E8-0x03EF or 0x02E8-0x02EF is serial activity and sets status bit 6. Addresses just outside these windows, such as 0x03F7, do not.
- R3: A strobed access in 0x0278-0x027F or 0x0378-0x037F is parallel activity and sets status bit 5. An access at 0x0380 does not.
- R4: The hints set status bits as follows: `video_hit` sets bit 4, `disk_hit` sets bit 3, `irq_hit` sets bit 1 and `dma_hit` sets bit 0. Status bit 2 always reads 0, even when written.
- R5: A status bit becomes visible on `act_status` one clock after its event and stays set until cleared. A register write with `reg_sel`=0 clears every status bit whose `reg_wdata` bit is 1. An event in the same cycle as a clear of its bit leaves the bit set.
- R6: `act_flag` rises one clock after a source occurs whose bit is set in the enable mask. It is cleared by a write with `reg_sel`=3 and `reg_wdata[0]`=1. A qualifying event in the same cycle keeps it set.
- R7: `gp1_reload` pulses for exactly one clock, in the cycle after a keyboard, serial, video or disk source occurs whose reload-mask bit (7, 6, 4 or 3 respectively) is set. Parallel, interrupt and DMA sources never pulse it.
- R8: `gp0_reload` pulses for exactly one clock, in the cycle after any source occurs, provided reload-mask bit 0 is set.
- R9: After reset, `act_status`, `act_flag`, both reload strobes, the enable mask and the reload mask are all zero.
- R10: A write with `reg_sel`=1 loads the enable mask and a write with `reg_sel`=2 loads the reload mask. A new mask applies to events from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe | input | 1 | I/O read or write cycle present this clock |
| io_addr | input | 16 | I/O port address of the cycle |
| video_hit | input | 1 | Video controller accessed |
| disk_hit | input | 1 | Disk or floppy controller accessed |
| irq_hit | input | 1 | Primary interrupt occurred |
| dma_hit | input | 1 | DMA or bus-master activity occurred |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status clear, 1 enable mask, 2 reload mask, 3 flag clear |
| reg_wdata | input | 8 | Register write data |
| act_status | output | 8 | Sticky per-source activity status |
| act_flag | output | 1 | Summary activity flag |
| gp0_reload | output | 1 | GP0 idle-timer reload pulse |
| gp1_reload | output | 1 | GP1 idle-timer reload pulse |

## Verification
The assertions check several rules on every cycle:
- the three address windows never match together;
- a source event always shows as a set status bit on the next clock;
- a set bit drops only through a matching clear;
- every reload pulse or rise of the summary flag has a qualifying source and mask bit behind it on the previous clock.

Only the bench scenarios can show the window edges, such as 0x0061, 0x03F7 and 0x0380 staying silent. The same goes for set-over-clear ordering seen at the ports, the exclusion of parallel, interrupt and DMA sources from GP1, and the one-clock delay before a newly written mask applies.

// File: rtl/act_pkg.sv
package act_pkg;
  localparam int SRC_W   = 8;
  localparam int ADDR_W  = 16;
  localparam int B_KBD   = 7;
  localparam int B_SER   = 6;
  localparam int B_PAR   = 5;
  localparam int B_VID   = 4;
  localparam int B_DSK   = 3;
  localparam int B_RSV   = 2;
  localparam int B_IRQ   = 1;
  localparam int B_DMA   = 0;
  localparam logic [SRC_W-1:0] VALID_MASK = ~(SRC_W'(1) << B_RSV);
  localparam logic [SRC_W-1:0] GP1_SRCS   = (SRC_W'(1) << B_KBD) | (SRC_W'(1) << B_SER)
                                          | (SRC_W'(1) << B_VID) | (SRC_W'(1) << B_DSK);

  typedef enum logic [1:0] {
    SEL_STAT_CLR = 2'd0,
    SEL_ENABLE   = 2'd1,
    SEL_RELOAD   = 2'd2,
    SEL_FLAG_CLR = 2'd3
  } reg_sel_e;

  function automatic logic hit_kbd(input logic [ADDR_W-1:0] a);
    return a == ADDR_W'(16'h0060);
  endfunction

  // eight-byte windows: compare everything above the low three bits
  function automatic logic in_win8(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    return a[ADDR_W-1:3] == base[ADDR_W-1:3];
  endfunction

  function automatic logic hit_ser(input logic [ADDR_W-1:0] a);
    return in_win8(a, ADDR_W'(16'h03F8)) || in_win8(a, ADDR_W'(16'h02F8)) ||
           in_win8(a, ADDR_W'(16'h03E8)) || in_win8(a, ADDR_W'(16'h02E8));
  endfunction

  function automatic logic hit_par(input logic [ADDR_W-1:0] a);
    return in_win8(a, ADDR_W'(16'h0278)) || in_win8(a, ADDR_W'(16'h0378));
  endfunction
endpackage

// File: rtl/act_decode.sv
module act_decode
  import act_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_strobe,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              video_hit,
  input  logic              disk_hit,
  input  logic              irq_hit,
  input  logic              dma_hit,
  output logic [SRC_W-1:0]  src
);
  logic kbd_ev, ser_ev, par_ev;

  assign kbd_ev = io_strobe && hit_kbd(io_addr);
  assign ser_ev = io_strobe && hit_ser(io_addr);
  assign par_ev = io_strobe && hit_par(io_addr);

  always_comb begin
    src        = '0;
    src[B_KBD] = kbd_ev;
    src[B_SER] = ser_ev;
    src[B_PAR] = par_ev;
    src[B_VID] = video_hit;
    src[B_DSK] = disk_hit;
    src[B_IRQ] = irq_hit;
    src[B_DMA] = dma_hit;
  end

  // R1 R2 R3: port windows are disjoint
  p_windows_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_ev, ser_ev, par_ev}));
endmodule

// File: rtl/act_status.sv
module act_status
  import act_pkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] clr_ev,
  input  logic [W-1:0] valid,
  output logic [W-1:0] stat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)           stat[i] <= 1'b0;
      else if (!valid[i])   stat[i] <= 1'b0;
      else if (set_ev[i])   stat[i] <= 1'b1;
      else if (clr_ev[i])   stat[i] <= 1'b0;
    end

    // R5: an event latches next clock, winning over a clear
    p_set_latches_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev[i] && valid[i]) |=> stat[i]);
    // R5: a set bit only falls through a clear
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] && !clr_ev[i]) |=> stat[i]);
  end
endmodule

// File: rtl/act_strobes.sv
module act_strobes
  import act_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [SRC_W-1:0] en_mask,
  input  logic [SRC_W-1:0] rld_mask,
  input  logic             flag_clr,
  output logic             flag,
  output logic             gp0,
  output logic             gp1
);
  logic flag_ev, gp0_ev, gp1_ev;

  assign flag_ev = |(src & en_mask);
  assign gp1_ev  = |(src & rld_mask & GP1_SRCS);
  assign gp0_ev  = (|src) && rld_mask[B_DMA];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      gp0  <= 1'b0;
      gp1  <= 1'b0;
    end else begin
      gp0 <= gp0_ev;
      gp1 <= gp1_ev;
      if (flag_ev)       flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  // R6: the flag rises only on an enabled source
  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(|(src & en_mask)));
  // R6: an enabled source always leaves the flag set
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src & en_mask)) |=> flag);
  // R7: GP1 pulses need a GP1 source with its reload bit
  p_gp1_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gp1 |-> $past(|(src & rld_mask & GP1_SRCS)));
  // R8: GP0 pulses need some source and reload bit 0
  p_gp0_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gp0 |-> $past((|src) && rld_mask[B_DMA]));
endmodule

// File: rtl/io_activity_monitor.sv
module io_activity_monitor
  import act_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_strobe,
  input  logic [15:0] io_addr,
  input  logic        video_hit,
  input  logic        disk_hit,
  input  logic        irq_hit,
  input  logic        dma_hit,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  act_status,
  output logic        act_flag,
  output logic        gp0_reload,
  output logic        gp1_reload
);
  logic [SRC_W-1:0] src;
  logic [SRC_W-1:0] en_mask, rld_mask;
  logic [SRC_W-1:0] stat_clr;
  logic             flag_clr;

  assign stat_clr = (reg_wr && reg_sel == SEL_STAT_CLR) ? reg_wdata : '0;
  assign flag_clr = reg_wr && reg_sel == SEL_FLAG_CLR && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask  <= '0;
      rld_mask <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_ENABLE) en_mask  <= reg_wdata & VALID_MASK;
      if (reg_sel == SEL_RELOAD) rld_mask <= reg_wdata & VALID_MASK;
    end
  end

  act_decode u_dec (
    .clk, .rst_n, .io_strobe, .io_addr,
    .video_hit, .disk_hit, .irq_hit, .dma_hit, .src
  );

  act_status #(.W(SRC_W)) u_stat (
    .clk, .rst_n, .set_ev(src), .clr_ev(stat_clr),
    .valid(VALID_MASK), .stat(act_status)
  );

  act_strobes u_stb (
    .clk, .rst_n, .src, .en_mask, .rld_mask, .flag_clr,
    .flag(act_flag), .gp0(gp0_reload), .gp1(gp1_reload)
  );

  // R4: the reserved status bit never reads as set
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_STAT_CLR) |=> !act_status[B_RSV]);
endmodule

// File: tb/sim_io_activity_monitor.sv
`timescale 1ns/100ps
module sim_io_activity_monitor;
  logic clk = 0, rst_n = 0;
  logic io_strobe = 0, video_hit = 0, disk_hit = 0, irq_hit = 0, dma_hit = 0;
  logic [15:0] io_addr = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] act_status;
  logic act_flag, gp0_reload, gp1_reload;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  int m_stat = 0, m_en = 0, m_rld = 0, m_flag = 0, m_gp0 = 0, m_gp1 = 0;

  always #2.5 clk = ~clk;

  io_activity_monitor u0 (.*);

  function automatic int ref_src();
    int s = 0;
    int blk = io_addr >> 3;
    if (io_strobe && io_addr == 96) s += 128;
    if (io_strobe && (blk == 'h7F || blk == 'h5F || blk == 'h7D || blk == 'h5D)) s += 64;
    if (io_strobe && (blk == 'h4F || blk == 'h6F)) s += 32;
    if (video_hit) s += 16;
    if (disk_hit)  s += 8;
    if (irq_hit)   s += 2;
    if (dma_hit)   s += 1;
    return s;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: model updates at the edge, outputs compared 1ns later
  task automatic step(string tag);
    int s, clr;
    @(posedge clk);
    s = ref_src();
    clr = (reg_wr && reg_sel == 0) ? reg_wdata : 0;
    m_gp1  = ((s & m_rld & 'hD8) != 0) ? 1 : 0;
    m_gp0  = (s != 0 && (m_rld & 1) != 0) ? 1 : 0;
    if ((s & m_en) != 0) m_flag = 1;
    else if (reg_wr && reg_sel == 3 && reg_wdata[0]) m_flag = 0;
    m_stat = ((m_stat & ~clr) | s) & 'hFB;
    if (reg_wr && reg_sel == 1) m_en  = reg_wdata & 'hFB;
    if (reg_wr && reg_sel == 2) m_rld = reg_wdata & 'hFB;
    #1;
    chk(tag, "status", act_status, m_stat);
    chk(tag, "flag",   act_flag,   m_flag);
    chk(tag, "gp0",    gp0_reload, m_gp0);
    chk(tag, "gp1",    gp1_reload, m_gp1);
    @(negedge clk);
    io_strobe = 0; video_hit = 0; disk_hit = 0; irq_hit = 0; dma_hit = 0; reg_wr = 0;
  endtask

  task automatic io(string tag, int a);
    io_strobe = 1; io_addr = a[15:0]; step(tag);
  endtask

  task automatic wr(string tag, int sel, int d);
    reg_wr = 1; reg_sel = sel[1:0]; reg_wdata = d[7:0]; step(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    step("R9");
    chk("R9", "status_direct", act_status, 0);
    // R9: masks zero: an event raises neither flag nor reload
    dma_hit = 1; step("R9");
    wr("R5", 0, 'hFF);
    // R10 mask loads, then used from next clock
    wr("R10", 1, 'hFF);
    wr("R10", 2, 'hFF);
    // R1 keyboard
    io("R1", 'h0061);
    io("R1", 'h0060);
    chk("R1", "bit7", act_status[7], 1);
    wr("R5", 0, 'hFF);
    // R2 serial windows and an outside address
    io("R2", 'h03F7);
    io("R2", 'h03F8);
    wr("R2", 0, 'h40);
    io("R2", 'h02FF);
    io("R2", 'h03EF);
    io("R2", 'h02E8);
    chk("R2", "bit6", act_status[6], 1);
    // R5 set wins over simultaneous clear
    io_strobe = 1; io_addr = 'h02EA; reg_wr = 1; reg_sel = 0; reg_wdata = 'h40; step("R5");
    chk("R5", "bit6_kept", act_status[6], 1);
    wr("R5", 0, 'hFF);
    chk("R5", "cleared", act_status, 0);
    // R3 parallel: no GP1 pulse but GP0 pulse (R7 R8)
    io("R3", 'h0380);
    io("R3", 'h0278);
    chk("R7", "par_no_gp1", gp1_reload, 0);
    chk("R8", "par_gp0", gp0_reload, 1);
    io("R3", 'h037F);
    // R4 hints and reserved bit
    video_hit = 1; step("R4");
    disk_hit = 1;  step("R4");
    irq_hit = 1;   step("R7");
    chk("R7", "irq_no_gp1", gp1_reload, 0);
    dma_hit = 1;   step("R4");
    wr("R4", 0, 'h04);
    chk("R4", "bit2", act_status[2], 0);
    wr("R4", 0, 'hFF);
    // R6 enable only DMA
    wr("R6", 3, 1);
    wr("R10", 1, 'h01);
    irq_hit = 1; step("R6");
    chk("R6", "irq_masked", act_flag, 0);
    dma_hit = 1; step("R6");
    chk("R6", "dma_flag", act_flag, 1);
    dma_hit = 1; reg_wr = 1; reg_sel = 3; reg_wdata = 1; step("R6");
    chk("R6", "set_wins", act_flag, 1);
    wr("R6", 3, 1);
    chk("R6", "cleared", act_flag, 0);
    // R7 R8 reload mask: only disk for GP1, GP0 disabled
    wr("R10", 2, 'h08);
    disk_hit = 1; step("R7");
    chk("R7", "disk_gp1", gp1_reload, 1);
    chk("R8", "no_gp0", gp0_reload, 0);
    step("R7");
    chk("R7", "single_pulse", gp1_reload, 0);
    io("R7", 'h0060);
    chk("R7", "kbd_masked", gp1_reload, 0);
    // R10 mask change applies the clock after
    reg_wr = 1; reg_sel = 2; reg_wdata = 'h81; io_strobe = 1; io_addr = 'h0060; step("R10");
    chk("R10", "old_mask", gp1_reload, 0);
    io("R10", 'h0060);
    chk("R10", "new_mask", gp1_reload, 1);
    chk("R8", "gp0_on", gp0_reload, 1);
    step("R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule